// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Threshold Flags

This block is a single-clock first-in first-out buffer. By default it holds 256 words of 18 bits, and the depth is a parameter. On the write side, a word is stored on each rising clock edge that has an active-low write request and room in the buffer. On the read side, a registered output advances by one word on each rising edge that has an active-low read request and stored data. The output register never advances on its own. The first word written into an empty buffer also needs its own read request before it appears. An active-low output enable either drives the output register onto the data pins or releases them.

The block has five active-low status flags: full, empty, almost-full, almost-empty and half-full. The almost-empty threshold n and the almost-full threshold m are inputs. A system can change them at any time, and they take effect at the next clock edge. An active-low program input freezes both data ports while it is LOW. All flags are registered and are computed from the word count that results from the edge.

Internally, a three-state occupancy machine (EMPTY, PARTIAL, FULL) decides which requests are honoured. Its transitions are FILL_FIRST (EMPTY to PARTIAL on the first accepted write), FILL_LAST (PARTIAL to FULL when the last free slot is written), DRAIN_FIRST (FULL to PARTIAL on a read) and DRAIN_LAST (PARTIAL to EMPTY when the last word is read). Any other cycle holds the state.

Top module: `fifo_pf`

## Requirements
- R1: While rst_n is LOW and after its release, before any accepted write, full_n, afull_n and half_n are 1, empty_n and aempty_n are 0, and the output register is all zeros.
- R2: With prog_n HIGH, wr_n LOW and fewer than DEPTH words stored, the word on din is stored on the rising edge. While full_n is 0, a write request stores nothing.
- R3: With prog_n HIGH, rd_n LOW and at least one word stored, the output register loads the oldest word on the rising edge. Otherwise it holds its value: this applies to an empty buffer and also to the first word after it is written.
- R4: Words leave in the order they were written. An accepted read and an accepted write on the same edge leave the count unchanged. Write plus read at full acts as a read only. Write plus read at empty acts as a write only.
- R5: aempty_n is 0 when the count is between 0 and ae_off inclusive, and 1 when the count is above ae_off.
- R6: afull_n is 0 when count + af_off is at least DEPTH, and 1 otherwise.
- R7: half_n is 0 when the count is above DEPTH/2, and 1 when it is DEPTH/2 or less.
- R8: full_n is 0 exactly when DEPTH words are stored. empty_n is 0 exactly when no word is stored, so it falls on the read of the last word and rises on the first write.
- R9: With oe_n HIGH, dout is high-impedance. With oe_n LOW, dout carries the output register.
- R10: While prog_n is LOW, neither read nor write requests change the stored data, the count or the output register.
- R11: Every flag is registered and shows the count that results from the rising edge, on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active LOW |
| din | input | W | Write data |
| wr_n | input | 1 | Write request, active LOW |
| rd_n | input | 1 | Read request, active LOW |
| prog_n | input | 1 | Data operations allowed when HIGH, frozen when LOW |
| oe_n | input | 1 | Output enable, active LOW |
| ae_off | input | CW | Almost-empty threshold n |
| af_off | input | CW | Almost-full threshold m |
| dout | output | W | Registered read data, high-impedance when oe_n is HIGH |
| full_n | output | 1 | Full flag, active LOW |
| empty_n | output | 1 | Empty flag, active LOW |
| afull_n | output | 1 | Almost-full flag, active LOW |
| aempty_n | output | 1 | Almost-empty flag, active LOW |
| half_n | output | 1 | Half-full flag, active LOW |

## Verification
The assertions assume that the threshold inputs stay at or below DEPTH. They also assume that the design is in reset for at least one clock before any request is made. Under those assumptions, the implications between flags hold: full implies almost-full and half-full, and empty implies almost-empty. The bench changes thresholds only in idle cycles and keeps them within range. It drives every request half a cycle away from the sampling edge. It deliberately pushes writes into a full buffer and reads into an empty one, because those are the cases the state machine must refuse.

// File: rtl/fifo_pf_pkg.sv
package fifo_pf_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_t;
endpackage

// File: rtl/fifo_pf_ptr.sv
module fifo_pf_ptr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [AW-1:0] ptr
);
    // Power-of-two depth: the pointer wraps by natural overflow.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr <= '0;
        else if (adv) ptr <= ptr + AW'(1);
    end
endmodule

// File: rtl/fifo_pf_store.sv
module fifo_pf_store #(
    parameter int W     = 18,
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Output register: advances only on an honoured read.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/fifo_pf_ctrl.sv
module fifo_pf_ctrl
    import fifo_pf_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int CW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic [CW-1:0] ae_off,
    input  logic [CW-1:0] af_off,
    output logic          wr_go,
    output logic          rd_go,
    output logic          full_n,
    output logic          empty_n,
    output logic          afull_n,
    output logic          aempty_n,
    output logic          half_n
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);
    localparam logic [CW:0]   FULL_EXT = (CW+1)'(DEPTH);

    occ_state_t    state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    // Which requests the current occupancy permits.
    always_comb begin
        wr_go = 1'b0;
        rd_go = 1'b0;
        unique case (state)
            OCC_EMPTY:   wr_go = wr_req;
            OCC_PARTIAL: begin
                wr_go = wr_req;
                rd_go = rd_req;
            end
            OCC_FULL:    rd_go = rd_req;
            default:     ;
        endcase
    end

    assign cnt_nxt = cnt + CW'(wr_go) - CW'(rd_go);

    // Transitions: FILL_FIRST, FILL_LAST, DRAIN_FIRST, DRAIN_LAST.
    always_comb begin
        state_nxt = state;
        unique case (state)
            OCC_EMPTY:   if (wr_go) state_nxt = OCC_PARTIAL;
            OCC_PARTIAL: begin
                if (cnt_nxt == '0)            state_nxt = OCC_EMPTY;
                else if (cnt_nxt == FULL_CNT) state_nxt = OCC_FULL;
            end
            OCC_FULL:    if (rd_go) state_nxt = OCC_PARTIAL;
            default:     state_nxt = OCC_EMPTY;
        endcase
    end

    // State and count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= OCC_EMPTY;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Registered flags from the post-edge count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_n   <= 1'b1;
            empty_n  <= 1'b0;
            afull_n  <= 1'b1;
            aempty_n <= 1'b0;
            half_n   <= 1'b1;
        end else begin
            full_n   <= (state_nxt != OCC_FULL);
            empty_n  <= (state_nxt != OCC_EMPTY);
            afull_n  <= ({1'b0, cnt_nxt} + {1'b0, af_off}) < FULL_EXT;
            aempty_n <= cnt_nxt > ae_off;
            half_n   <= cnt_nxt <= HALF_CNT;
        end
    end
endmodule

// File: rtl/fifo_pf.sv
module fifo_pf #(
    parameter int W     = 18,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  din,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic          prog_n,
    input  logic          oe_n,
    input  logic [CW-1:0] ae_off,
    input  logic [CW-1:0] af_off,
    output logic [W-1:0]  dout,
    output logic          full_n,
    output logic          empty_n,
    output logic          afull_n,
    output logic          aempty_n,
    output logic          half_n
);
    logic          wr_go, rd_go;
    logic [AW-1:0] wptr, rptr;
    logic [W-1:0]  rd_data;

    fifo_pf_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (!wr_n && prog_n),
        .rd_req   (!rd_n && prog_n),
        .ae_off   (ae_off),
        .af_off   (af_off),
        .wr_go    (wr_go),
        .rd_go    (rd_go),
        .full_n   (full_n),
        .empty_n  (empty_n),
        .afull_n  (afull_n),
        .aempty_n (aempty_n),
        .half_n   (half_n)
    );

    fifo_pf_ptr #(.AW(AW)) u_wptr (
        .clk (clk), .rst_n (rst_n), .adv (wr_go), .ptr (wptr)
    );

    fifo_pf_ptr #(.AW(AW)) u_rptr (
        .clk (clk), .rst_n (rst_n), .adv (rd_go), .ptr (rptr)
    );

    fifo_pf_store #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_go),
        .waddr (wptr),
        .wdata (din),
        .re    (rd_go),
        .raddr (rptr),
        .rdata (rd_data)
    );

    assign dout = oe_n ? {W{1'bz}} : rd_data;
endmodule

// File: rtl/fifo_pf_chk.sv
module fifo_pf_chk #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_n,
    input logic         rd_n,
    input logic         prog_n,
    input logic         full_n,
    input logic         empty_n,
    input logic         afull_n,
    input logic         aempty_n,
    input logic         half_n,
    input logic [W-1:0] rd_data
);
    // R8: full and empty never together
    assert_full_empty_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!full_n && !empty_n));

    // R3: a read request on an empty buffer leaves the output register alone
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && !rd_n) |=> $stable(rd_data));

    // R2: a write without a read cannot leave the full state
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && rd_n) |=> !full_n);

    // R8: an honoured write into an empty buffer clears empty
    assert_write_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && !wr_n && prog_n) |=> empty_n);

    // R5: zero words is always within the almost-empty band
    assert_empty_is_aempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);

    // R6: a full buffer is always almost full
    assert_full_is_afull_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !afull_n);

    // R7: a full buffer is more than half full
    assert_full_is_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !half_n);

    // R10: with ports frozen, the flags do not move
    assert_frozen_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_n && full_n && empty_n) |=> (full_n && empty_n));
endmodule

bind fifo_pf fifo_pf_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_n     (wr_n),
    .rd_n     (rd_n),
    .prog_n   (prog_n),
    .full_n   (full_n),
    .empty_n  (empty_n),
    .afull_n  (afull_n),
    .aempty_n (aempty_n),
    .half_n   (half_n),
    .rd_data  (rd_data)
);

// File: tb/tb_fifo_pf.sv
module tb_fifo_pf;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 18;
    localparam int D  = 256;
    localparam int CW = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [W-1:0]  din;
    logic          wr_n, rd_n, prog_n, oe_n;
    logic [CW-1:0] ae_off, af_off;
    wire  [W-1:0]  dout;
    logic          full_n, empty_n, afull_n, aempty_n, half_n;

    int checks = 0;
    int fails  = 0;

    // Independent model
    logic [W-1:0] mq[$];
    logic [W-1:0] exp_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_pf #(.W(W), .DEPTH(D)) dut (
        .clk(clk), .rst_n(rst_n), .din(din), .wr_n(wr_n), .rd_n(rd_n),
        .prog_n(prog_n), .oe_n(oe_n), .ae_off(ae_off), .af_off(af_off),
        .dout(dout), .full_n(full_n), .empty_n(empty_n), .afull_n(afull_n),
        .aempty_n(aempty_n), .half_n(half_n)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: drive after negedge, update model, sample at next negedge.
    task automatic cycle(bit w, bit r, bit p, logic [W-1:0] d);
        int cnt;
        bit wok, rok;
        din = d; wr_n = !w; rd_n = !r; prog_n = p;
        cnt = mq.size();
        wok = w && p && (cnt < D);
        rok = r && p && (cnt > 0);
        @(posedge clk);
        if (rok) exp_q = mq.pop_front();
        if (wok) mq.push_back(d);
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b1; prog_n = 1'b1;
    endtask

    // R11: every flag already reflects the new count right after the edge
    task automatic check_flags(string tag);
        int c;
        c = mq.size();
        check({tag, " R8 empty R11"}, 32'(empty_n),  32'(c != 0));
        check({tag, " R8 full R11"},  32'(full_n),   32'(c != D));
        check({tag, " R5 aempty"},    32'(aempty_n), 32'(c > int'(ae_off)));
        check({tag, " R6 afull"},     32'(afull_n),  32'(!(c + int'(af_off) >= D)));
        check({tag, " R7 half"},      32'(half_n),   32'(!(c > D/2)));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; prog_n = 1'b1; oe_n = 1'b0;
        din = '0; ae_off = CW'(31); af_off = CW'(31);
        mq.delete(); exp_q = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 empty_n",  32'(empty_n),  32'(0));
        check("R1 aempty_n", 32'(aempty_n), 32'(0));
        check("R1 full_n",   32'(full_n),   32'(1));
        check("R1 afull_n",  32'(afull_n),  32'(1));
        check("R1 half_n",   32'(half_n),   32'(1));
        check("R1 dout",     32'(dout),     32'(0));
    endtask

    task automatic t_first_word();
        do_reset();
        cycle(1, 0, 1, 18'h2A5A5);
        check("R3 no fallthrough", 32'(dout), 32'(0));
        check_flags("first");
        cycle(0, 1, 1, '0);
        check("R3 first read", 32'(dout), 32'(18'h2A5A5));
        check_flags("first-read");
        cycle(0, 1, 1, '0);
        check("R3 read empty holds", 32'(dout), 32'(18'h2A5A5));
        check_flags("underflow");
    endtask

    task automatic t_fill_drain(int n, int m);
        do_reset();
        ae_off = CW'(n); af_off = CW'(m);
        cycle(0, 0, 1, '0);
        check_flags("fill-idle");
        for (int i = 0; i < D; i++) begin
            cycle(1, 0, 1, W'(18'h1000 + i));
            check_flags("fill");
        end
        cycle(1, 0, 1, 18'h3FFFF);
        check("R2 full size", 32'(mq.size()), 32'(D));
        check_flags("overflow");
        for (int i = 0; i < D; i++) begin
            cycle(0, 1, 1, '0);
            check("R4 order", 32'(dout), 32'(18'h1000 + i));
            check_flags("drain");
        end
        cycle(0, 1, 1, '0);
        check("R2 overflow word dropped", 32'(dout), 32'(18'h1000 + D - 1));
        check_flags("drained");
    endtask

    task automatic t_simul();
        do_reset();
        cycle(1, 1, 1, 18'h00111);
        check("R4 empty w+r dout", 32'(dout), 32'(0));
        check("R4 empty w+r count", 32'(empty_n), 32'(1));
        for (int i = 0; i < 4; i++) cycle(1, 0, 1, W'(18'h00200 + i));
        for (int i = 0; i < 6; i++) begin
            cycle(1, 1, 1, W'(18'h00300 + i));
            check("R4 simul dout", 32'(dout), 32'(exp_q));
            check_flags("simul");
        end
        while (mq.size() < D) cycle(1, 0, 1, W'(18'h00400 + mq.size()));
        check("R8 full reached", 32'(full_n), 32'(0));
        cycle(1, 1, 1, 18'h3ABCD);
        check("R4 full w+r read only", 32'(full_n), 32'(1));
        check("R4 full w+r dout", 32'(dout), 32'(exp_q));
        check_flags("full-wr");
    endtask

    task automatic t_frozen();
        logic [W-1:0] held;
        do_reset();
        cycle(1, 0, 1, 18'h0BEEF);
        cycle(1, 0, 1, 18'h0CAFE);
        cycle(0, 1, 1, '0);
        held = dout;
        cycle(1, 1, 0, 18'h01234);
        check("R10 dout frozen", 32'(dout), 32'(held));
        check_flags("frozen");
        cycle(0, 1, 1, '0);
        check("R10 no write while frozen", 32'(dout), 32'(18'h0CAFE));
        check("R10 empty after", 32'(empty_n), 32'(0));
    endtask

    task automatic t_oe();
        do_reset();
        cycle(1, 0, 1, 18'h15555);
        cycle(0, 1, 1, '0);
        check("R9 driven", 32'(dout), 32'(18'h15555));
        oe_n = 1'b1;
        #1;
        checks++;
        if (dout === 18'h15555) begin
            fails++;
            $display("FAIL R9 released actual=%0h expected=z", dout);
        end
        oe_n = 1'b0;
        #1;
        check("R9 driven again", 32'(dout), 32'(18'h15555));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_first_word();
        t_fill_drain(31, 31);
        t_fill_drain(0, 0);
        t_fill_drain(5, 200);
        t_simul();
        t_frozen();
        t_oe();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule